// File: doc/BRIEF.md
# Power-Stage Fault Rearm Controller

This block supervises a switching power stage for two kinds of fault: a sustained overcurrent (a short on the output) and die overheating. Once per switching period a cycle strobe closes the period. If the peak-current comparator fired anywhere in that period, the period counts as a trip. When a run of back-to-back trip periods reaches a limit, the stage is shut off for a fixed hold-off window. A thermal-shutdown input that rises while the stage is running also shuts the stage off, and the stage stays off until that input falls again. The comparator is expected to provide the 150 °C trip point and the 120 °C release point itself.

After either fault, a rearm input selects what happens next. With rearm set, the stage restarts by itself and keeps its settings. With rearm clear, the stage stays latched off until the enable pin is taken low and then high again. The block also gives an immediate high-side-off command when the peak comparator fires, and it selects a peak-current threshold from a 2-bit code for the external comparator. Sticky interrupt flags record both the start and the end of each fault.

Top module: `fault_rearm_ctrl`

## Requirements
- R1: After reset the stage enable and both interrupt flags are 0, and the high-side-off output is 0 while the peak-trip input is 0.
- R2: While idle, the enable pin going high turns the stage enable on at the next clock edge. The enable pin low at any clock edge leaves the stage enable 0 after that edge.
- R3: The high-side-off output follows the peak-trip input without a clock delay. Once set, it stays high until the clock edge that samples the cycle strobe.
- R4: The stage enable drops at the strobe edge that completes the TRIP_LIMIT-th consecutive trip period. Fewer consecutive trip periods leave it on.
- R5: A strobed period with no peak trip resets the consecutive count to zero, so trip runs split by a clean period do not add up.
- R6: After a short shutdown the stage enable stays 0 for exactly HOLD_TICKS clock cycles. With rearm = 1 and the enable pin high, it then returns to 1.
- R7: With rearm = 0, the stage stays off after the hold-off or after a thermal fault clears. It restarts only after the enable pin has been low and then high.
- R8: The thermal input high while the stage runs turns the stage enable off at the next edge. While the stage is idle (enable pin low), the thermal input has no effect on the outputs or the flags.
- R9: The stage remains off while the thermal input stays high. When it falls, recovery follows the rearm input as in R6 and R7.
- R10: Each interrupt flag is set one clock after its fault begins and again one clock after it ends. A flag stays set until the clear input is sampled high.
- R11: The threshold output gives the peak limit in mA for the 2-bit code: 0→5200, 1→5800, 2→6200, 3→6800.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_pin_i | input | 1 | Enable pin level |
| rearm_i | input | 1 | 1 = automatic restart, 0 = latch off until enable toggles |
| pk_trip_i | input | 1 | Peak-current comparator output |
| cyc_strobe_i | input | 1 | One-clock pulse closing a switching period |
| therm_hot_i | input | 1 | Thermal-shutdown comparator (with hysteresis) |
| ilim_sel_i | input | 2 | Peak-current threshold code |
| irq_clr_i | input | 1 | Clears both interrupt flags |
| stage_en_o | output | 1 | Power stage enable |
| hs_off_o | output | 1 | Immediate high-side switch off command |
| irq_short_o | output | 1 | Sticky short-circuit event flag |
| irq_therm_o | output | 1 | Sticky thermal event flag |
| thr_ma_o | output | 13 | Selected peak threshold in mA |

## Verification
The bench builds the block with TRIP_LIMIT = 4 and HOLD_TICKS = 8. With these values every run length from one trip period up to one past the limit can be swept under both rearm settings, and the full hold-off window can be counted cycle by cycle. The thermal entry, exit and latch paths, the split-run case and all four threshold codes are covered in the same short run.

// File: rtl/frc_pkg.sv
package frc_pkg;

    localparam int THR_W = 13;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_HOLD  = 3'd2,
        ST_HOT   = 3'd3,
        ST_LATCH = 3'd4
    } frc_state_e;

    typedef struct packed {
        frc_state_e st;
    } frc_fsm_t;

    function automatic logic [THR_W-1:0] thr_of_code(input logic [1:0] code);
        logic [THR_W-1:0] v;
        unique case (code)
            2'd0:    v = THR_W'(5200);
            2'd1:    v = THR_W'(5800);
            2'd2:    v = THR_W'(6200);
            default: v = THR_W'(6800);
        endcase
        return v;
    endfunction

endpackage

// File: rtl/frc_trip_counter.sv
module frc_trip_counter #(
    parameter int TRIP_LIMIT = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic pk_trip_i,
    input  logic cyc_strobe_i,
    output logic hs_off_o,
    output logic short_o
);
    localparam int CNT_W = (TRIP_LIMIT > 1) ? $clog2(TRIP_LIMIT + 1) : 1;

    typedef struct packed {
        logic             seen;
        logic [CNT_W-1:0] cnt;
    } trip_regs_t;

    trip_regs_t r_d, r_q;
    logic       period_trip;

    assign period_trip = r_q.seen | pk_trip_i;
    assign hs_off_o    = period_trip;

    always_comb begin
        r_d     = r_q;
        short_o = 1'b0;
        if (cyc_strobe_i) begin
            r_d.seen = 1'b0;
        end else begin
            r_d.seen = period_trip;
        end
        if (!run_i) begin
            r_d.cnt = '0;
        end else if (cyc_strobe_i) begin
            if (period_trip) begin
                if (r_q.cnt == CNT_W'(TRIP_LIMIT - 1)) begin
                    short_o = 1'b1;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end else begin
                r_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/frc_holdoff_timer.sv
module frc_holdoff_timer #(
    parameter int HOLD_TICKS = 200000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic done_o
);
    localparam int TMR_W = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;

    typedef struct packed {
        logic             busy;
        logic [TMR_W-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t r_d, r_q;

    assign done_o = r_q.busy && (r_q.cnt == '0);

    always_comb begin
        r_d = r_q;
        if (start_i) begin
            r_d.busy = 1'b1;
            r_d.cnt  = TMR_W'(HOLD_TICKS - 1);
        end else if (r_q.busy) begin
            if (r_q.cnt == '0) begin
                r_d.busy = 1'b0;
            end else begin
                r_d.cnt = r_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/frc_irq_flags.sv
module frc_irq_flags (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic short_act_i,
    input  logic hot_act_i,
    input  logic clr_i,
    output logic irq_short_o,
    output logic irq_therm_o
);
    typedef struct packed {
        logic short_prev;
        logic hot_prev;
        logic short_flag;
        logic hot_flag;
    } irq_regs_t;

    irq_regs_t r_d, r_q;

    assign irq_short_o = r_q.short_flag;
    assign irq_therm_o = r_q.hot_flag;

    always_comb begin
        r_d            = r_q;
        r_d.short_prev = short_act_i;
        r_d.hot_prev   = hot_act_i;
        if (clr_i) begin
            r_d.short_flag = 1'b0;
            r_d.hot_flag   = 1'b0;
        end
        if (short_act_i != r_q.short_prev) begin
            r_d.short_flag = 1'b1;
        end
        if (hot_act_i != r_q.hot_prev) begin
            r_d.hot_flag = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/fault_rearm_ctrl.sv
module fault_rearm_ctrl
    import frc_pkg::*;
#(
    parameter int TRIP_LIMIT = 16,
    parameter int HOLD_TICKS = 200000
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_pin_i,
    input  logic             rearm_i,
    input  logic             pk_trip_i,
    input  logic             cyc_strobe_i,
    input  logic             therm_hot_i,
    input  logic [1:0]       ilim_sel_i,
    input  logic             irq_clr_i,
    output logic             stage_en_o,
    output logic             hs_off_o,
    output logic             irq_short_o,
    output logic             irq_therm_o,
    output logic [THR_W-1:0] thr_ma_o
);
    frc_fsm_t   f_d, f_q;
    logic       running;
    logic       short_evt;
    logic       tmr_start;
    logic       tmr_done;
    frc_state_e resume_st;

    assign running    = (f_q.st == ST_RUN);
    assign stage_en_o = running;
    assign thr_ma_o   = thr_of_code(ilim_sel_i);
    assign tmr_start  = running && en_pin_i && short_evt;

    frc_trip_counter #(
        .TRIP_LIMIT (TRIP_LIMIT)
    ) i_trip (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .run_i        (running),
        .pk_trip_i    (pk_trip_i),
        .cyc_strobe_i (cyc_strobe_i),
        .hs_off_o     (hs_off_o),
        .short_o      (short_evt)
    );

    frc_holdoff_timer #(
        .HOLD_TICKS (HOLD_TICKS)
    ) i_tmr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (tmr_start),
        .done_o  (tmr_done)
    );

    frc_irq_flags i_irq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .short_act_i (f_q.st == ST_HOLD),
        .hot_act_i   (f_q.st == ST_HOT),
        .clr_i       (irq_clr_i),
        .irq_short_o (irq_short_o),
        .irq_therm_o (irq_therm_o)
    );

    always_comb begin
        if (!en_pin_i) begin
            resume_st = ST_IDLE;
        end else if (rearm_i) begin
            resume_st = ST_RUN;
        end else begin
            resume_st = ST_LATCH;
        end
    end

    always_comb begin
        f_d = f_q;
        unique case (f_q.st)
            ST_IDLE: begin
                if (en_pin_i) f_d.st = ST_RUN;
            end
            ST_RUN: begin
                if (!en_pin_i) begin
                    f_d.st = ST_IDLE;
                end else if (short_evt) begin
                    f_d.st = ST_HOLD;
                end else if (therm_hot_i) begin
                    f_d.st = ST_HOT;
                end
            end
            ST_HOLD: begin
                if (tmr_done) f_d.st = resume_st;
            end
            ST_HOT: begin
                if (!therm_hot_i) f_d.st = resume_st;
            end
            ST_LATCH: begin
                if (!en_pin_i) f_d.st = ST_IDLE;
            end
            default: f_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            f_q.st <= ST_IDLE;
        end else begin
            f_q <= f_d;
        end
    end
endmodule

// File: rtl/fault_rearm_ctrl_chk.sv
module fault_rearm_ctrl_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        en_pin_i,
    input logic        pk_trip_i,
    input logic        therm_hot_i,
    input logic        irq_clr_i,
    input logic        stage_en_o,
    input logic        hs_off_o,
    input logic        irq_short_o,
    input logic        irq_therm_o
);
    AST_EN_LOW_STAGE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(en_pin_i) |-> !stage_en_o); // R2

    AST_TRIP_FORCES_HSOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pk_trip_i |-> hs_off_o); // R3

    AST_SHORT_NEEDS_TRIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(stage_en_o) && $past(en_pin_i) && !$past(therm_hot_i)) |-> $past(hs_off_o)); // R4

    AST_HOT_STOPS_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stage_en_o && therm_hot_i) |=> !stage_en_o); // R8

    AST_SHORT_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_short_o && !irq_clr_i) |=> irq_short_o); // R10

    AST_HOT_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_therm_o && !irq_clr_i) |=> irq_therm_o); // R10
endmodule

bind fault_rearm_ctrl fault_rearm_ctrl_chk i_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_pin_i    (en_pin_i),
    .pk_trip_i   (pk_trip_i),
    .therm_hot_i (therm_hot_i),
    .irq_clr_i   (irq_clr_i),
    .stage_en_o  (stage_en_o),
    .hs_off_o    (hs_off_o),
    .irq_short_o (irq_short_o),
    .irq_therm_o (irq_therm_o)
);

// File: tb/test_fault_rearm_ctrl.sv
`timescale 1ns/1ps
module test_fault_rearm_ctrl;
    localparam int LIM  = 4;
    localparam int HOLD = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, rearm = 1'b0, pk = 1'b0, strobe = 1'b0, hot = 1'b0, clr = 1'b0;
    logic [1:0]  sel = 2'd0;
    logic        stage, hsoff, irq_s, irq_t;
    logic [12:0] thr;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    fault_rearm_ctrl #(.TRIP_LIMIT(LIM), .HOLD_TICKS(HOLD)) i_fault_rearm_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .en_pin_i(en), .rearm_i(rearm), .pk_trip_i(pk),
        .cyc_strobe_i(strobe), .therm_hot_i(hot), .ilim_sel_i(sel), .irq_clr_i(clr),
        .stage_en_o(stage), .hs_off_o(hsoff), .irq_short_o(irq_s), .irq_therm_o(irq_t),
        .thr_ma_o(thr));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic sw_cycle(input logic trip);
        pk = trip; strobe = 1'b0; #1;
        chk("R3 hs_off immediate", hsoff, trip);
        step();
        pk = 1'b0; strobe = 1'b1; #1;
        chk("R3 hs_off held to strobe", hsoff, trip);
        step();
        strobe = 1'b0; #1;
        chk("R3 hs_off released", hsoff, 0);
    endtask

    task automatic restart();
        en = 1'b0; step(); en = 1'b1; step();
        clr = 1'b1; step(); clr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 stage", stage, 0);
        chk("R1 irq_short", irq_s, 0);
        chk("R1 irq_therm", irq_t, 0);
        chk("R1 hs_off", hsoff, 0);

        // R11 threshold code sweep
        for (int c = 0; c < 4; c++) begin
            int e;
            sel = 2'(c); #1;
            e = (c == 0) ? 5200 : (c == 1) ? 5800 : (c == 2) ? 6200 : 6800;
            chk("R11 threshold", thr, e);
        end

        // R2 enable pin
        en = 1'b1; step(); chk("R2 start", stage, 1);
        en = 1'b0; step(); chk("R2 stop", stage, 0);
        en = 1'b1; step(); chk("R2 restart", stage, 1);

        // R4 R6 R7 R10 run-length sweep under both rearm settings
        for (int rm = 0; rm < 2; rm++) begin
            for (int n = 1; n <= LIM + 1; n++) begin
                bit shut;
                rearm = rm[0];
                restart();
                shut = 1'b0;
                for (int k = 1; k <= n; k++) begin
                    if (!shut) begin
                        sw_cycle(1'b1);
                        chk("R4 stage vs run length", stage, (k < LIM) ? 1 : 0);
                        if (k == LIM) shut = 1'b1;
                    end
                end
                if (!shut) begin
                    sw_cycle(1'b0);
                    chk("R4 short run keeps stage", stage, 1);
                    chk("R10 no short flag", irq_s, 0);
                end else begin
                    for (int h = 1; h < HOLD; h++) begin
                        step();
                        chk("R6 hold-off low", stage, 0);
                    end
                    chk("R10 short flag on entry", irq_s, 1);
                    step();
                    chk(rm ? "R6 auto restart" : "R7 latched", stage, rm);
                    if (rm == 0) begin
                        repeat (3) step();
                        chk("R7 still latched", stage, 0);
                        en = 1'b0; step(); en = 1'b1; step();
                        chk("R7 toggle restart", stage, 1);
                    end
                end
            end
        end

        // R5 split runs do not accumulate
        rearm = 1'b1;
        restart();
        for (int k = 0; k < LIM - 1; k++) sw_cycle(1'b1);
        sw_cycle(1'b0);
        for (int k = 0; k < LIM - 1; k++) sw_cycle(1'b1);
        chk("R5 split run keeps stage", stage, 1);
        sw_cycle(1'b1);
        chk("R5 full run after clean", stage, 0);
        repeat (HOLD) step();
        chk("R6 back on", stage, 1);

        // R10 dual-edge short flag: clear during hold, exit sets it again
        restart();
        for (int k = 0; k < LIM; k++) sw_cycle(1'b1);
        step();
        chk("R10 short flag set", irq_s, 1);
        clr = 1'b1; step(); clr = 1'b0;
        chk("R10 short flag cleared", irq_s, 0);
        repeat (HOLD) step();
        chk("R10 short flag on exit", irq_s, 1);
        chk("R6 running after exit", stage, 1);

        // R8 thermal ignored while idle
        en = 1'b0; step(); clr = 1'b1; step(); clr = 1'b0;
        hot = 1'b1; repeat (4) step();
        chk("R8 idle stage", stage, 0);
        chk("R8 idle no therm flag", irq_t, 0);
        hot = 1'b0; step();
        chk("R8 idle no therm flag after", irq_t, 0);

        // R8 R9 R10 thermal with auto restart
        rearm = 1'b1; en = 1'b1; step();
        chk("R2 running", stage, 1);
        hot = 1'b1; step();
        chk("R8 thermal off", stage, 0);
        step();
        chk("R10 therm flag on entry", irq_t, 1);
        clr = 1'b1; step(); clr = 1'b0;
        chk("R10 therm flag cleared", irq_t, 0);
        repeat (3) step();
        chk("R9 off while hot", stage, 0);
        chk("R10 therm flag stays clear", irq_t, 0);
        hot = 1'b0; step();
        chk("R9 auto restart", stage, 1);
        step();
        chk("R10 therm flag on exit", irq_t, 1);

        // R9 thermal with latch-off
        rearm = 1'b0;
        hot = 1'b1; step();
        chk("R8 thermal off again", stage, 0);
        hot = 1'b0; repeat (3) step();
        chk("R9 latched after cool", stage, 0);
        en = 1'b0; step(); en = 1'b1; step();
        chk("R9 toggle restart", stage, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule